// File: doc/BRIEF.md
# Multi-lane SPI frame shifter

This block is the master-side serial engine of an SPI controller. One start strobe moves one data frame of 0 to 8 bits over one, two or four data lanes. When a frame is accepted the engine works out how many serial-clock pulses it needs. That number is the frame length divided by the lane count, rounded up. The engine then issues exactly that many pulses and never an extra one, because an extra edge would throw the slave out of step.

Transmit data is taken left-aligned from the transmit byte and sent most significant bit first. Received bits are collected right-aligned into the receive byte. The serial clock comes from a fixed divider parameter. It idles low, input lanes are sampled on its rising edge and output lanes change on its falling edge. A one-cycle done pulse marks the end of every frame, including frames of length zero.

Top module: `lane_frame_shifter`

## Requirements
- R1: The number of rising serial-clock edges per frame is ceil(L/N). L is the effective length and N is the lane count given by the mode: 2'b00 single (N=1), 2'b01 dual (N=2), 2'b10 quad (N=4), 2'b11 treated as single.
- R2: A start with length 0 produces no serial-clock pulse, and done_o is high in the cycle right after the start edge.
- R3: sclk_o is low after reset and whenever no frame runs. Each half period lasts DIV system clocks. The first rise follows the start edge by DIV clocks. done_o is high exactly 2*P*DIV clocks after the start edge, where P is the pulse count, and sclk_o is low at that point.
- R4: Frame bit q (q=0 first) is tx_i[7-q]. In pulse p, the k-th bit of that pulse (q = p*N+k) is driven on lane N-1-k. So single mode uses lane 0, dual mode drives lane 1 then lane 0, and quad mode drives lanes 3 down to 0.
- R5: A lane that carries no valid frame bit in a pulse drives 0. This covers lanes outside the selected mode and the lanes past the end of the frame in a partial last pulse. All lanes drive 0 while idle.
- R6: At each rising serial-clock edge the engine samples the lanes that carry valid bits, using the same lane order as R4, and discards the others. rx_o is cleared by reset and by an accepted start. It ends the frame holding the L received bits right-aligned, first received bit highest, and holds that value until the next start.
- R7: lane_o does not change while sclk_o stays high.
- R8: start_i is ignored while a frame is running, including the clock edge that ends it. Such a start produces no pulse and no extra done.
- R9: done_o is a single-cycle pulse, exactly one per accepted start.
- R10: A length above 8 is treated as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| len_i | input | 4 | Frame length in bits (0..8, larger values clamp to 8) |
| mode_i | input | 2 | Lane mode: 00 single, 01 dual, 10 quad, 11 single |
| tx_i | input | 8 | Transmit byte, sent from bit 7 downward |
| lane_i | input | 4 | Incoming data lanes |
| sclk_o | output | 1 | Serial clock, idles low |
| lane_o | output | 4 | Outgoing data lanes |
| rx_o | output | 8 | Received bits, right-aligned |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The ending of a frame and a new start request can land on the same clock edge. The bench raises start_i in the cycle just before the final falling serial-clock edge. It then checks that the edge produces only the expected done pulse, and that no new serial clock and no second done follow. A second collision is a start raised in the middle of a frame. There the bench checks that the pulse count, the lane data and the done timing stay exactly as a reference model predicts, cycle by cycle, for the frame already running.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
    localparam int LFS_DATA_W   = 8;
    localparam int LFS_LEN_W    = 4;
    localparam int LFS_LANE_MAX = 4;
    localparam int LFS_SH_W     = $clog2(LFS_LANE_MAX);
    localparam int LFS_MAX_LEN  = LFS_DATA_W;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'b00,
        LM_DUAL   = 2'b01,
        LM_QUAD   = 2'b10,
        LM_RSVD   = 2'b11
    } lane_mode_e;

    function automatic logic [LFS_SH_W-1:0] lane_shift(input logic [1:0] mode);
        case (lane_mode_e'(mode))
            LM_DUAL: lane_shift = LFS_SH_W'(1);
            LM_QUAD: lane_shift = LFS_SH_W'(2);
            default: lane_shift = '0;
        endcase
    endfunction

    typedef struct packed {
        logic                  run;
        logic                  sclk;
        logic                  done;
        logic [LFS_SH_W-1:0]   shamt;
        logic [LFS_LEN_W-1:0]  pulses_left;
        logic [LFS_LEN_W-1:0]  bits_left;
        logic [LFS_DATA_W-1:0] tx_sr;
        logic [LFS_DATA_W-1:0] rx_sr;
    } lfs_state_t;
endpackage

// File: rtl/lfs_cycle_calc.sv
module lfs_cycle_calc
    import lfs_pkg::*;
(
    input  logic [LFS_LEN_W-1:0] len_i,
    input  logic [1:0]           mode_i,
    output logic [LFS_LEN_W-1:0] len_o,
    output logic [LFS_LEN_W-1:0] pulses_o
);
    localparam int NOPT = LFS_SH_W + 1;

    logic [LFS_LEN_W-1:0] len_c;
    logic [LFS_LEN_W-1:0] cand [NOPT];

    always_comb begin
        len_c = (len_i > LFS_LEN_W'(LFS_MAX_LEN)) ? LFS_LEN_W'(LFS_MAX_LEN) : len_i;
    end

    // One candidate per lane width: quotient plus a carry when any low bit is set.
    for (genvar g = 0; g < NOPT; g++) begin : g_opt
        if (g == 0) begin : g_one
            assign cand[g] = len_c;
        end else begin : g_multi
            assign cand[g] = (len_c >> g) + LFS_LEN_W'(|len_c[g-1:0]);
        end
    end

    always_comb begin
        len_o    = len_c;
        pulses_o = cand[lane_shift(mode_i)];
    end
endmodule

// File: rtl/lfs_tick.sv
module lfs_tick #(
    parameter int DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == CW'(DIV - 1));
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/lane_frame_shifter.sv
module lane_frame_shifter
    import lfs_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [LFS_LEN_W-1:0]    len_i,
    input  logic [1:0]              mode_i,
    input  logic [LFS_DATA_W-1:0]   tx_i,
    input  logic [LFS_LANE_MAX-1:0] lane_i,
    output logic                    sclk_o,
    output logic [LFS_LANE_MAX-1:0] lane_o,
    output logic [LFS_DATA_W-1:0]   rx_o,
    output logic                    done_o
);
    localparam int DATA_W = LFS_DATA_W;
    localparam int LANES  = LFS_LANE_MAX;
    localparam int IDX_W  = LFS_SH_W;

    lfs_state_t st_d, st_q;

    logic [LFS_LEN_W-1:0] len_c;
    logic [LFS_LEN_W-1:0] pulses;
    logic                 tick;
    logic [LANES-1:0]     drive;
    logic [DATA_W-1:0]    cap;
    int                   nlanes;
    int                   nvalid;

    lfs_cycle_calc u_calc (
        .len_i    (len_i),
        .mode_i   (mode_i),
        .len_o    (len_c),
        .pulses_o (pulses)
    );

    lfs_tick #(.DIV(DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (st_q.run),
        .tick_o (tick)
    );

    // Lane mapping for the current pulse: valid bits from the top of tx_sr,
    // earliest bit on the highest lane in use.
    always_comb begin
        nlanes = 1 << st_q.shamt;
        nvalid = (int'(st_q.bits_left) < nlanes) ? int'(st_q.bits_left) : nlanes;
        drive  = '0;
        cap    = st_q.rx_sr;
        for (int k = 0; k < LANES; k++) begin
            if (k < nvalid) begin
                drive[IDX_W'(nlanes - 1 - k)] = st_q.tx_sr[DATA_W-1-k];
                cap = {cap[DATA_W-2:0], lane_i[IDX_W'(nlanes - 1 - k)]};
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.run) begin
            if (start_i) begin
                st_d.tx_sr       = tx_i;
                st_d.rx_sr       = '0;
                st_d.shamt       = lane_shift(mode_i);
                st_d.bits_left   = len_c;
                st_d.pulses_left = pulses;
                st_d.sclk        = 1'b0;
                if (pulses == '0) st_d.done = 1'b1;
                else              st_d.run  = 1'b1;
            end
        end else if (tick) begin
            if (!st_q.sclk) begin
                st_d.sclk        = 1'b1;
                st_d.rx_sr       = cap;
                st_d.pulses_left = st_q.pulses_left - LFS_LEN_W'(1);
            end else begin
                st_d.sclk = 1'b0;
                if (st_q.pulses_left == '0) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.tx_sr     = st_q.tx_sr << nlanes;
                    st_d.bits_left = st_q.bits_left - LFS_LEN_W'(nvalid);
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sclk_o = st_q.sclk;
    assign lane_o = st_q.run ? drive : '0;
    assign rx_o   = st_q.rx_sr;
    assign done_o = st_q.done;
endmodule

// File: rtl/lfs_checker.sv
module lfs_checker
    import lfs_pkg::*;
#(
    parameter int DIV = 2
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic [LFS_LEN_W-1:0]    len_i,
    input logic [1:0]              mode_i,
    input logic                    sclk_o,
    input logic [LFS_LANE_MAX-1:0] lane_o,
    input logic                    done_o
);
    logic busy_q, single_q, sclk_prev_q;
    int   need_q, rises_q;
    int   len_e, lanes_e, need_e;
    logic accept;

    always_comb begin
        len_e   = (int'(len_i) > LFS_MAX_LEN) ? LFS_MAX_LEN : int'(len_i);
        lanes_e = (mode_i == 2'b01) ? 2 : (mode_i == 2'b10) ? 4 : 1;
        need_e  = (len_e + lanes_e - 1) / lanes_e;
        accept  = start_i && (!busy_q || done_o);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            busy_q <= 1'b0; single_q <= 1'b0; sclk_prev_q <= 1'b0;
            need_q <= 0;    rises_q  <= 0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (accept) begin
                busy_q   <= (need_e > 0);
                single_q <= (lanes_e == 1);
                need_q   <= need_e;
                rises_q  <= 0;
            end else begin
                if (done_o) busy_q <= 1'b0;
                if (sclk_o && !sclk_prev_q) rises_q <= rises_q + 1;
            end
        end
    end

    p_pulse_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rises_q <= need_q);
    p_idle_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_q |-> !sclk_o);
    p_done_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !sclk_o);
    p_single_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_q && single_q) |-> (lane_o[LFS_LANE_MAX-1:1] == '0));
    p_lane_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && $past(sclk_o)) |-> $stable(lane_o));
    p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

bind lane_frame_shifter lfs_checker #(.DIV(DIV)) u_lfs_checker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .len_i   (len_i),
    .mode_i  (mode_i),
    .sclk_o  (sclk_o),
    .lane_o  (lane_o),
    .done_o  (done_o)
);

// File: tb/lane_frame_shifter_bench.sv
module lane_frame_shifter_bench;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] len = '0;
    logic [1:0] mode = '0;
    logic [7:0] tx = '0;
    logic [3:0] lane_in = 4'hF;
    logic       sclk;
    logic [3:0] lane_out;
    logic [7:0] rx;
    logic       done;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    lane_frame_shifter #(.DIV(DIV)) u_lane_frame_shifter (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len), .mode_i(mode),
        .tx_i(tx), .lane_i(lane_in), .sclk_o(sclk), .lane_o(lane_out),
        .rx_o(rx), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] m);
        return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    endfunction

    // Reference lane pattern for pulse p; invalid lanes given fill value.
    function automatic logic [3:0] pat(input int p, input int l, input int n,
                                       input logic [7:0] src, input logic fill);
        logic [3:0] v = {4{fill}};
        for (int k = 0; k < n; k++) begin
            int q = p * n + k;
            if (q < l) v[n-1-k] = src[7-q];
        end
        return v;
    endfunction

    function automatic logic [3:0] vmask(input int p, input int l, input int n);
        logic [3:0] v = '0;
        for (int k = 0; k < n; k++) if (p * n + k < l) v[n-1-k] = 1'b1;
        return v;
    endfunction

    task automatic frame(input int l_in, input logic [1:0] m, input logic [7:0] t,
                         input logic [7:0] src, input bit mid_start, input bit end_start);
        int l = (l_in > 8) ? 8 : l_in;
        int n = lanes_of(m);
        int np = (l + n - 1) / n;
        int tdone = 2 * np * DIV;
        int rises = 0, dones = 0, tseen = -1;
        logic prev_s = 1'b0;
        logic [3:0] prev_l = '0;
        logic [7:0] exp_rx = (l == 0) ? 8'h00 : 8'(src >> (8 - l));
        @(negedge clk);
        start = 1'b1; len = 4'(l_in); mode = m; tx = t;
        lane_in = pat(0, l, n, src, 1'b1);
        @(posedge clk);
        for (int tt = 0; tt <= tdone + 2; tt++) begin
            @(negedge clk);
            start = 1'b0;
            if (mid_start && tt == 1 && np > 0) begin start = 1'b1; len = 4'd8; mode = 2'b10; end
            if (end_start && np > 0 && tt == tdone - 1) begin start = 1'b1; len = 4'd8; mode = 2'b00; end
            // Reference serial-clock level at this cycle (R3).
            begin
                bit hi = 1'b0;
                for (int p = 0; p < np; p++)
                    if (tt >= 2*p*DIV + DIV && tt < 2*p*DIV + 2*DIV) hi = 1'b1;
                chk(sclk == hi, "R3 sclk level", sclk, hi);
            end
            if (sclk && prev_s) chk(lane_out == prev_l, "R7 lanes held while sclk high", lane_out, prev_l);
            if (sclk && !prev_s) begin
                logic [3:0] msk = vmask(rises, l, n);
                logic [3:0] ev  = pat(rises, l, n, t, 1'b0);
                chk((lane_out & msk) == ev, "R4 lane data", lane_out & msk, ev);
                chk((lane_out & ~msk) == 4'h0, "R5 unused lanes zero", lane_out & ~msk, 0);
                rises++;
                lane_in = pat(rises, l, n, src, 1'b1);
            end
            if (done) begin dones++; if (tseen < 0) tseen = tt; end
            prev_s = sclk; prev_l = lane_out;
        end
        chk(rises == np, (l == 0) ? "R2 no pulses for empty frame" : "R1 pulse count", rises, np);
        chk(tseen == tdone, (l == 0) ? "R2 done timing" : "R3 done timing", tseen, tdone);
        chk(dones == 1, "R9 single done", dones, 1);
        chk(rx == exp_rx, "R6 received bits", rx, exp_rx);
        chk(lane_out == 4'h0, "R5 idle lanes", lane_out, 0);
        if (mid_start || end_start) begin
            int extra = 0;
            for (int tt = 0; tt < 4 * DIV + 2; tt++) begin
                @(negedge clk);
                if (sclk || done) extra++;
            end
            chk(extra == 0, "R8 start ignored during frame", extra, 0);
            chk(rx == exp_rx, "R8 rx unchanged by ignored start", rx, exp_rx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0, "R3 reset sclk low", sclk, 0);
        chk(lane_out == 4'h0, "R5 reset lanes zero", lane_out, 0);
        chk(rx == 8'h00, "R6 reset rx clear", rx, 0);
        chk(done == 1'b0, "R9 reset done low", done, 0);
        rst_n = 1'b1;
        for (int m = 0; m < 3; m++)
            for (int l = 0; l <= 8; l++)
                frame(l, 2'(m), 8'hA5 ^ 8'(l * 37 + m), 8'h3C ^ 8'(l * 19 + m * 7), 1'b0, 1'b0);
        frame(5, 2'b11, 8'hD2, 8'h9B, 1'b0, 1'b0);   // R1 reserved mode acts as single
        frame(12, 2'b10, 8'h6E, 8'hC1, 1'b0, 1'b0);  // R10 clamp in quad
        frame(15, 2'b00, 8'h81, 8'h7E, 1'b0, 1'b0);  // R10 clamp in single
        frame(7, 2'b01, 8'hF0, 8'h55, 1'b1, 1'b0);   // R8 start mid-frame
        frame(5, 2'b10, 8'hB7, 8'hE4, 1'b0, 1'b1);   // R8 start on finishing edge
        frame(3, 2'b00, 8'h4C, 8'hA9, 1'b1, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule